// File: doc/BRIEF.md
# Paged Address Translator with Associative Translation Buffer

This block turns a logical address into a physical address under a single-level paged memory model. The low `OFF_W` bits of the logical address pass through unchanged as the page offset. The upper bits form the page number. The page number is looked up in a small fully associative buffer of recent translations. On a hit the stored frame number is joined to the offset, and the response comes out on the next cycle with no memory traffic.

On a miss the block issues one read of a page table entry. The entry address is the page-table base input plus the page number times the entry size in bytes. Memory returns the entry, and the block uses it to answer the request. If the entry is valid, the block also writes it into the buffer. The read, write and execute permission bits of the entry are checked against the requested access. A failed check, or an entry whose valid bit is clear, gives a fault code instead of an address.

A context switch is handled by changing the base input and pulsing the flush input. The flush empties the buffer so that no mapping from the previous context can be used.

Top module: `page_xlat`

## Requirements
- R1: A successful translation returns `rsp_paddr = {frame, offset}`. Here `frame` is the entry's frame number and `offset` is `req_vaddr[OFF_W-1:0]`, and `rsp_fault` is 2'b00.
- R2: When a request is accepted and its page is held in the buffer, `rsp_valid` is high in the next cycle. No memory read is issued.
- R3: When a request is accepted and its page is not in the buffer, `mem_rd_req` pulses for exactly one cycle, in the cycle after acceptance. `mem_rd_addr` equals `pt_base + page*2`. `rsp_valid` rises in the cycle after `mem_rsp_valid`, and `req_ready` stays low from acceptance until the response.
- R4: A valid entry fetched on a miss is loaded into the buffer, so a later request to the same page hits. The entry layout is: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bits 15:4 frame.
- R5: An entry with bit 0 clear gives `rsp_fault = 2'b01` and `rsp_paddr = 0`. Such an entry is never loaded, so a repeat request for that page reads memory again.
- R6: The access code is 2'b00 read, 2'b01 write and 2'b10 execute, and 2'b11 is never permitted. An access whose permission bit is clear gives `rsp_fault = 2'b10` and `rsp_paddr = 0`. The check is the same whether the entry comes from the buffer or from memory.
- R7: A `flush` pulse empties the buffer. A request accepted in the same cycle as `flush` is treated as a miss.
- R8: If `flush` is high while a miss is waiting for memory, the response is still produced from the fetched entry. That entry is not loaded into the buffer.
- R9: On a refill, empty slots are filled first, lowest index first. When the buffer is full, the victim is chosen by a round-robin pointer. The pointer starts at slot 0 and advances only when it has been used.
- R10: After reset `req_ready` is 1, `rsp_valid` and `mem_rd_req` are 0, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the translation buffer |
| pt_base | input | MEM_AW | Byte address of the page table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid page, 2 protection |
| mem_rd_req | output | 1 | Entry read strobe |
| mem_rd_addr | output | MEM_AW | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | PTE_W | Page table entry |

## Verification
The hardest states to reach from the ports are the ones where the buffer is full and the round-robin pointer picks the victim. The bench flushes the buffer and fills all eight slots with distinct pages, then confirms each one hits. It then forces a chain of misses in which each newly fetched page evicts the next older one. Each eviction shows up only as a memory read on a page that hit shortly before, so the bench counts memory reads per request to detect it. A flush that lands between the entry read and its return is made by the memory model, which raises `flush` in the cycle it sees the read strobe.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_INVALID = 2'b01,
      FLT_PROT    = 2'b10
   } flt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_FETCH = 2'b01,
      ST_WAIT  = 2'b10
   } st_e;

   // entry layout: bit 0 valid, bits 3:1 permissions (r, w, x), frame above
   localparam int PTE_V_BIT    = 0;
   localparam int PTE_PERM_LSB = 1;
   localparam int PTE_FRM_LSB  = 4;
endpackage

// File: rtl/pxl_perm_chk.sv
module pxl_perm_chk
   import pxl_pkg::*;
(
   input  logic [2:0] perm,
   input  logic [1:0] acc,
   output logic       allow
);
   always_comb begin
      case (acc)
         ACC_READ:  allow = perm[0];
         ACC_WRITE: allow = perm[1];
         ACC_EXEC:  allow = perm[2];
         default:   allow = 1'b0;
      endcase
   end
endmodule

// File: rtl/pxl_tlb.sv
module pxl_tlb #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 8,
   parameter int FRAME_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic [VPN_W-1:0]   lk_vpn_i,
   output logic [ENTRIES-1:0] lk_match_o,
   output logic               lk_hit_o,
   output logic [FRAME_W-1:0] lk_frame_o,
   output logic [2:0]         lk_perm_o,
   input  logic               fill_i,
   input  logic [VPN_W-1:0]   fill_vpn_i,
   input  logic [FRAME_W-1:0] fill_frame_i,
   input  logic [2:0]         fill_perm_i
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("pxl_tlb: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0] ent_vld;
   logic [VPN_W-1:0]   ent_vpn [ENTRIES];
   logic [FRAME_W-1:0] ent_frm [ENTRIES];
   logic [2:0]         ent_prm [ENTRIES];
   logic [IDX_W-1:0]   rr_ptr;
   logic [IDX_W-1:0]   free_idx;
   logic [IDX_W-1:0]   victim;
   logic               have_free;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match_o[g] = ent_vld[g] && (ent_vpn[g] == lk_vpn_i);
   end

   assign lk_hit_o = |lk_match_o;

   always_comb begin
      lk_frame_o = '0;
      lk_perm_o  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match_o[i]) begin
            lk_frame_o = lk_frame_o | ent_frm[i];
            lk_perm_o  = lk_perm_o  | ent_prm[i];
         end
      end
   end

   always_comb begin
      have_free = 1'b0;
      free_idx  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!ent_vld[i]) begin
            have_free = 1'b1;
            free_idx  = IDX_W'(i);
         end
      end
   end

   assign victim = have_free ? free_idx : rr_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld <= '0;
         rr_ptr  <= '0;
      end else if (flush_i) begin
         ent_vld <= '0;
      end else if (fill_i) begin
         ent_vld[victim] <= 1'b1;
         if (!have_free) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_i && !flush_i) begin
         ent_vpn[victim] <= fill_vpn_i;
         ent_frm[victim] <= fill_frame_i;
         ent_prm[victim] <= fill_perm_i;
      end
   end
endmodule

// File: rtl/page_xlat.sv
module page_xlat
   import pxl_pkg::*;
#(
   parameter int VA_W    = 16,
   parameter int OFF_W   = 8,
   parameter int FRAME_W = 12,
   parameter int PTE_W   = 16,
   parameter int MEM_AW  = 16,
   parameter int ENTRIES = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [MEM_AW-1:0]        pt_base,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [VA_W-1:0]          req_vaddr,
   input  logic [1:0]               req_acc,
   output logic                     rsp_valid,
   output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
   output logic [1:0]               rsp_fault,
   output logic                     mem_rd_req,
   output logic [MEM_AW-1:0]        mem_rd_addr,
   input  logic                     mem_rsp_valid,
   input  logic [PTE_W-1:0]         mem_rsp_data
);
   localparam int VPN_W     = VA_W - OFF_W;
   localparam int PA_W      = FRAME_W + OFF_W;
   localparam int PTE_BYTES = PTE_W / 8;
   localparam int PTE_SH    = $clog2(PTE_BYTES);

   if (PTE_W != PTE_FRM_LSB + FRAME_W) begin : g_bad_pte
      $error("page_xlat: PTE_W must equal FRAME_W + 4");
   end
   if ((PTE_W % 8) != 0 || (1 << PTE_SH) != PTE_BYTES) begin : g_bad_bytes
      $error("page_xlat: entry size must be a power-of-two number of bytes");
   end
   if (VPN_W < 1 || OFF_W < 1) begin : g_bad_split
      $error("page_xlat: address split leaves an empty field");
   end

   st_e                st_q;
   logic [VPN_W-1:0]   q_vpn;
   logic [OFF_W-1:0]   q_off;
   logic [1:0]         q_acc;
   logic               q_stale;

   logic [VPN_W-1:0]   req_vpn;
   logic [OFF_W-1:0]   req_off;
   logic [ENTRIES-1:0] lk_match;
   logic               lk_hit;
   logic [FRAME_W-1:0] lk_frame;
   logic [2:0]         lk_perm;
   logic               use_hit;
   logic               accept;

   logic               pte_v;
   logic [2:0]         pte_perm;
   logic [FRAME_W-1:0] pte_frame;
   logic               in_wait;
   logic [2:0]         chk_perm;
   logic [1:0]         chk_acc;
   logic               allow;
   logic               fill;

   assign req_vpn = req_vaddr[VA_W-1:OFF_W];
   assign req_off = req_vaddr[OFF_W-1:0];

   assign pte_v     = mem_rsp_data[PTE_V_BIT];
   assign pte_perm  = mem_rsp_data[PTE_PERM_LSB +: 3];
   assign pte_frame = mem_rsp_data[PTE_FRM_LSB +: FRAME_W];

   assign req_ready  = (st_q == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign use_hit    = lk_hit && !flush;
   assign in_wait    = (st_q == ST_WAIT);
   assign mem_rd_req = (st_q == ST_FETCH);
   assign mem_rd_addr = pt_base + (MEM_AW'(q_vpn) << PTE_SH);

   // one permission checker serves both the buffer and the memory path
   assign chk_perm = in_wait ? pte_perm : lk_perm;
   assign chk_acc  = in_wait ? q_acc : req_acc;

   assign fill = in_wait && mem_rsp_valid && pte_v && !q_stale && !flush;

   pxl_tlb #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .FRAME_W (FRAME_W)
   ) u_tlb (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (flush),
      .lk_vpn_i     (req_vpn),
      .lk_match_o   (lk_match),
      .lk_hit_o     (lk_hit),
      .lk_frame_o   (lk_frame),
      .lk_perm_o    (lk_perm),
      .fill_i       (fill),
      .fill_vpn_i   (q_vpn),
      .fill_frame_i (pte_frame),
      .fill_perm_i  (pte_perm)
   );

   pxl_perm_chk u_perm (
      .perm  (chk_perm),
      .acc   (chk_acc),
      .allow (allow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         q_vpn     <= '0;
         q_off     <= '0;
         q_acc     <= '0;
         q_stale   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= FLT_NONE;
      end else begin
         rsp_valid <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  if (use_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_paddr <= allow ? {lk_frame, req_off} : PA_W'(0);
                     rsp_fault <= allow ? FLT_NONE : FLT_PROT;
                  end else begin
                     q_vpn   <= req_vpn;
                     q_off   <= req_off;
                     q_acc   <= req_acc;
                     q_stale <= 1'b0;
                     st_q    <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (flush) q_stale <= 1'b1;
               st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (flush) q_stale <= 1'b1;
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  st_q      <= ST_IDLE;
                  if (!pte_v) begin
                     rsp_paddr <= '0;
                     rsp_fault <= FLT_INVALID;
                  end else if (!allow) begin
                     rsp_paddr <= '0;
                     rsp_fault <= FLT_PROT;
                  end else begin
                     rsp_paddr <= {pte_frame, q_off};
                     rsp_fault <= FLT_NONE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk #(
   parameter int ENTRIES = 8,
   parameter int PA_W    = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush,
   input logic               req_valid,
   input logic               req_ready,
   input logic               lk_hit,
   input logic [ENTRIES-1:0] lk_match,
   input logic               rsp_valid,
   input logic [PA_W-1:0]    rsp_paddr,
   input logic [1:0]         rsp_fault,
   input logic               mem_rd_req
);
   assert_hit_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && lk_hit && !flush) |=> (rsp_valid && !mem_rd_req));

   assert_miss_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !(lk_hit && !flush)) |=> (mem_rd_req && !req_ready));

   assert_fetch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);

   assert_fetch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !req_ready);

   // R5 and R6: a faulting response carries no address
   assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

   assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault != 2'b11));

   assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (lk_match == '0));

   assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
endmodule

bind page_xlat page_xlat_chk #(
   .ENTRIES (ENTRIES),
   .PA_W    (FRAME_W + OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .lk_hit     (lk_hit),
   .lk_match   (lk_match),
   .rsp_valid  (rsp_valid),
   .rsp_paddr  (rsp_paddr),
   .rsp_fault  (rsp_fault),
   .mem_rd_req (mem_rd_req)
);

// File: tb/sim_page_xlat.sv
`timescale 1ns/1ps
module sim_page_xlat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [15:0] pt_base = 16'h0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        rsp_valid;
   logic [19:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        mem_rd_req;
   logic [15:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [15:0] mem_rsp_data = '0;

   int nchk = 0;
   int nfail = 0;
   logic [15:0] ptm [1024];

   always #4 clk = ~clk;

   page_xlat u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [15:0] mk(input logic [11:0] frm, input logic v,
                                      input logic r, input logic w, input logic x);
      return {frm, x, w, r, v};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // expected result from the entry layout and access codes (R1, R5, R6)
   task automatic expect_of(input logic [15:0] va, input logic [1:0] acc,
                            output logic [19:0] pa, output logic [1:0] flt);
      logic [15:0] ea;
      logic [15:0] pte;
      logic ok;
      ea  = pt_base + {7'b0, va[15:8], 1'b0};
      pte = ptm[ea[10:1]];
      case (acc)
         2'b00:   ok = pte[1];
         2'b01:   ok = pte[2];
         2'b10:   ok = pte[3];
         default: ok = 1'b0;
      endcase
      if (!pte[0]) begin
         pa = '0; flt = 2'b01;
      end else if (!ok) begin
         pa = '0; flt = 2'b10;
      end else begin
         pa = {pte[15:4], va[7:0]}; flt = 2'b00;
      end
   endtask

   task automatic run(input string tag, input logic [15:0] va, input logic [1:0] acc,
                      input bit fl_req, input bit fl_mid, input int exp_rd);
      int nrd, ncyc;
      bit pend;
      logic [15:0] rd_addr;
      logic [19:0] epa;
      logic [1:0] eflt;
      expect_of(va, acc, epa, eflt);
      @(negedge clk);
      chk(tag, "ready before request", {31'b0, req_ready}, 32'd1);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc; flush = fl_req;
      @(negedge clk);
      req_valid = 1'b0; flush = 1'b0;
      nrd = 0; ncyc = 1; pend = 1'b0; rd_addr = '0;
      while (!rsp_valid && ncyc < 20) begin
         if (mem_rd_req) begin
            nrd++; rd_addr = mem_rd_addr; pend = 1'b1;
            chk(tag, "ready low during walk", {31'b0, req_ready}, 32'd0);
            if (fl_mid) flush = 1'b1;
         end else if (pend) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = ptm[rd_addr[10:1]];
            pend = 1'b0; flush = 1'b0;
         end else begin
            mem_rsp_valid = 1'b0; flush = 1'b0;
         end
         @(negedge clk);
         ncyc++;
      end
      mem_rsp_valid = 1'b0; flush = 1'b0;
      chk(tag, "response seen", {31'b0, rsp_valid}, 32'd1);
      chk(tag, "paddr", {12'b0, rsp_paddr}, {12'b0, epa});
      chk(tag, "fault", {30'b0, rsp_fault}, {30'b0, eflt});
      chk(tag, "memory reads", nrd, exp_rd);
      chk(tag, "latency", ncyc, (exp_rd != 0) ? 3 : 1);
      if (exp_rd != 0)
         chk(tag, "entry address", {16'b0, rd_addr}, {16'b0, pt_base + {7'b0, va[15:8], 1'b0}});
      @(negedge clk);
      chk(tag, "single response", {31'b0, rsp_valid}, 32'd0);
   endtask

   task automatic pulse_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10", "req_ready", {31'b0, req_ready}, 32'd1);
      chk("R10", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
      chk("R10", "mem_rd_req", {31'b0, mem_rd_req}, 32'd0);
   endtask

   task automatic t_miss_hit();
      run("R10_R3_R1", 16'h1234, 2'b00, 0, 0, 1);
      run("R4_R2_R1", 16'h12FE, 2'b01, 0, 0, 0);
      run("R2", 16'h1200, 2'b00, 0, 0, 0);
   endtask

   task automatic t_invalid();
      run("R5", 16'h3010, 2'b00, 0, 0, 1);
      run("R5", 16'h3011, 2'b00, 0, 0, 1);
   endtask

   task automatic t_perm();
      run("R6_miss", 16'h4000, 2'b01, 0, 0, 1);
      run("R6_hit", 16'h4005, 2'b00, 0, 0, 0);
      run("R6_hit", 16'h4006, 2'b10, 0, 0, 0);
      run("R6_rsvd", 16'h4007, 2'b11, 0, 0, 0);
      run("R6_miss", 16'h4120, 2'b10, 0, 0, 1);
      run("R6_hit", 16'h4121, 2'b00, 0, 0, 0);
      run("R6_hit", 16'h1233, 2'b10, 0, 0, 0);
   endtask

   task automatic t_flush();
      run("R7", 16'h1201, 2'b00, 0, 0, 0);
      pulse_flush();
      run("R7", 16'h1202, 2'b00, 0, 0, 1);
      run("R7", 16'h1203, 2'b00, 0, 0, 0);
      run("R7_same_cycle", 16'h1204, 2'b00, 1, 0, 1);
   endtask

   task automatic t_flush_mid();
      pulse_flush();
      run("R8", 16'h5011, 2'b01, 0, 1, 1);
      run("R8", 16'h5012, 2'b00, 0, 0, 1);
      run("R8", 16'h5013, 2'b00, 0, 0, 0);
   endtask

   task automatic t_base();
      pulse_flush();
      pt_base = 16'h0200;
      run("R3_base", 16'h1234, 2'b00, 0, 0, 1);
      pulse_flush();
      pt_base = 16'h0000;
      run("R3_base", 16'h1234, 2'b00, 0, 0, 1);
   endtask

   task automatic t_replace();
      pulse_flush();
      for (int p = 0; p < 8; p++) run("R9_fill", {8'h60 + 8'(p), 8'h0C}, 2'b00, 0, 0, 1);
      for (int p = 0; p < 8; p++) run("R9_held", {8'h60 + 8'(p), 8'h0D}, 2'b00, 0, 0, 0);
      run("R9_evict0", 16'h6800, 2'b00, 0, 0, 1);
      run("R9", 16'h6101, 2'b00, 0, 0, 0);
      run("R9_slot0_gone", 16'h6002, 2'b00, 0, 0, 1);
      run("R9", 16'h6203, 2'b00, 0, 0, 0);
      run("R9_slot1_gone", 16'h6104, 2'b00, 0, 0, 1);
      run("R9", 16'h6305, 2'b00, 0, 0, 0);
      run("R9", 16'h6806, 2'b00, 0, 0, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         ptm[i]       = mk({4'h0, 8'(i) ^ 8'hA5}, 1'b1, 1'b1, 1'b1, 1'b0);
         ptm[256 + i] = mk({4'h1, 8'(i) ^ 8'h3C}, 1'b1, 1'b1, 1'b1, 1'b0);
      end
      for (int i = 512; i < 1024; i++) ptm[i] = '0;
      ptm[16'h30] = mk(12'h777, 1'b0, 1'b1, 1'b1, 1'b1);
      ptm[16'h40] = mk(12'h840, 1'b1, 1'b1, 1'b0, 1'b0);
      ptm[16'h41] = mk(12'h941, 1'b1, 1'b0, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_miss_hit();
      t_invalid();
      t_perm();
      t_flush();
      t_flush_mid();
      t_base();
      t_replace();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule